// File: doc/BRIEF.md
# Burst-of-Four Read Port Pipeline

This block is the read half of a separate-port burst memory core. A memory access always moves a burst of four words. Four parallel banks hold the array, one bank for each word position in the burst, so a single array access reads a whole burst at once. The double-rate output is shown as two word lanes per clock: a rise lane and a fall lane. A burst therefore leaves the block over two consecutive clock cycles, lowest-order word first. A valid flag stands in for the output-enable behaviour of a real pad.

The read select is active-high inside the block. When it is sampled high, the block registers a burst address and reads the four banks. The block then presents the burst two rising edges later. A read can start at most on every other edge. A request on the edge right after an accepted read is dropped without any trace. Reads spaced exactly two cycles apart therefore give an output stream with no gaps.

A full-burst write input fills the banks. A write is held in a staging register for one cycle before it is committed to the banks. A bypass path makes sure that a read sees every write issued on or before its own accepting edge.

Top module: `burst4_read_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rd_vld_o` is 0 and both lanes are 0. A read select sampled during reset produces no output.
- R2: A read accepted at rising edge E drives `rd_vld_o`=1 after edge E+2, with word 0 on `rd_rise_o` and word 1 on `rd_fall_o`. After edge E+3 it drives word 2 on the rise lane and word 3 on the fall lane.
- R3: Word k (k = 0..3) of the burst at address A is the word held in bank k at A. A write places `wr_data_i` bits [18k+17:18k] into bank k.
- R4: A read select sampled high on the edge right after an accepted read is ignored. No data from it ever appears. When the select is held high on every edge, the accepted edges alternate with the dropped ones.
- R5: Reads accepted every other edge produce a continuous output with `rd_vld_o` high on every cycle.
- R6: When no burst is pending, `rd_vld_o` falls after the next rising edge that follows the last beat. Both lanes read 0 whenever `rd_vld_o` is 0.
- R7: A read returns the data of a write to the same address issued on the same edge as the read, or on the edge before it.
- R8: A write issued on any edge after a read's accepting edge does not change the data that read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel_i | input | 1 | Read request, active high |
| rd_addr_i | input | ADDR_W (8) | Burst address of the read |
| wr_en_i | input | 1 | Full-burst write request |
| wr_addr_i | input | ADDR_W (8) | Burst address of the write |
| wr_data_i | input | 4*WORD_W (72) | Four write words; word k in bits [18k+17:18k] |
| rd_vld_o | output | 1 | Output lanes carry valid read data |
| rd_rise_o | output | WORD_W (18) | Rise-lane word (word 0, then word 2) |
| rd_fall_o | output | WORD_W (18) | Fall-lane word (word 1, then word 3) |

## Verification
The first beat pair of a read accepted at edge E is due after edge E+2, and the second pair after edge E+3. The bench keeps a cycle-indexed ring of expected output. Each stimulus applied before edge n+1 fills the slots for edges n+3 and n+4. At every falling edge the bench compares the outputs against the slot for the edges seen so far, and checks idle slots for a low valid flag and zero lanes. Expected burst contents come from a bench memory model. In that model a write takes effect before a read issued on the same step, and after any earlier read, which covers the forwarding and late-write cases.

// File: rtl/b4rp_pkg.sv
package b4rp_pkg;
   localparam int BEATS = 4;
   localparam int LANES = 2;
   localparam int PHASES = BEATS / LANES;
endpackage

// File: rtl/b4rp_ctrl.sv
module b4rp_ctrl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              accept,
   output logic              fetch_vld,
   output logic [ADDR_W-1:0] fetch_addr
);
   // fetch_vld marks an accepted read on the previous edge; it blocks the next one
   assign accept = rd_sel && !fetch_vld && !rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         fetch_vld <= 1'b0;
      end else begin
         fetch_vld <= accept;
      end
      if (accept) fetch_addr <= rd_addr;
   end
endmodule

// File: rtl/b4rp_banks.sv
module b4rp_banks
   import b4rp_pkg::*;
#(
   parameter int WORD_W = 18,
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BEATS*WORD_W-1:0] wr_data,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic                    rd_vld,
   output logic [BEATS*WORD_W-1:0] rd_data
);
   logic                    wq_vld;
   logic [ADDR_W-1:0]       wq_addr;
   logic [BEATS*WORD_W-1:0] wq_data;
   logic                    hit;

   // staging register: a write lands here first and reaches the banks one edge later
   always_ff @(posedge clk) begin
      if (rst) begin
         wq_vld <= 1'b0;
         rd_vld <= 1'b0;
      end else begin
         wq_vld <= wr_en;
         rd_vld <= rd_en;
      end
      if (wr_en) begin
         wq_addr <= wr_addr;
         wq_data <= wr_data;
      end
   end

   // staged write not yet in the banks but addressed by the fetch: bypass it
   assign hit = wq_vld && (wq_addr == rd_addr);

   for (genvar b = 0; b < BEATS; b++) begin : g_bank
      logic [WORD_W-1:0] cells [DEPTH];
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (wq_vld) cells[wq_addr] <= wq_data[b*WORD_W +: WORD_W];
         if (rd_en) word_q <= hit ? wq_data[b*WORD_W +: WORD_W] : cells[rd_addr];
      end

      assign rd_data[b*WORD_W +: WORD_W] = word_q;
   end
endmodule

// File: rtl/b4rp_serial.sv
module b4rp_serial
   import b4rp_pkg::*;
#(
   parameter int WORD_W = 18
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_vld,
   input  logic [BEATS*WORD_W-1:0] in_data,
   output logic                    out_vld,
   output logic [WORD_W-1:0]       out_rise,
   output logic [WORD_W-1:0]       out_fall
);
   logic tail_pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld   <= 1'b0;
         tail_pend <= 1'b0;
      end else begin
         out_vld   <= in_vld || tail_pend;
         tail_pend <= in_vld;
      end
   end

   logic [WORD_W-1:0] lane_q [LANES];

   // lane l carries word l in the first phase and word LANES+l in the second
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WORD_W-1:0] tail_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            lane_q[l] <= '0;
            tail_q    <= '0;
         end else if (in_vld) begin
            lane_q[l] <= in_data[l*WORD_W +: WORD_W];
            tail_q    <= in_data[(LANES+l)*WORD_W +: WORD_W];
         end else if (tail_pend) begin
            lane_q[l] <= tail_q;
         end else begin
            lane_q[l] <= '0;
         end
      end
   end

   assign out_rise = lane_q[0];
   assign out_fall = lane_q[1];
endmodule

// File: rtl/burst4_read_port.sv
module burst4_read_port
   import b4rp_pkg::*;
#(
   parameter  int WORD_W = 18,
   parameter  int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    rd_sel_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-1:0]       wr_addr_i,
   input  logic [BEATS*WORD_W-1:0] wr_data_i,
   output logic                    rd_vld_o,
   output logic [WORD_W-1:0]       rd_rise_o,
   output logic [WORD_W-1:0]       rd_fall_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("burst4_read_port: DEPTH must be a power of two of at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("burst4_read_port: WORD_W must be positive");
   end
   if (BEATS != 2 * LANES) begin : g_bad_beats
      $error("burst4_read_port: a burst must fill exactly two lane phases");
   end

   logic                    acc_w;
   logic                    fetch_vld;
   logic [ADDR_W-1:0]       fetch_addr;
   logic                    burst_vld;
   logic [BEATS*WORD_W-1:0] burst_data;

   b4rp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .rd_sel     (rd_sel_i),
      .rd_addr    (rd_addr_i),
      .accept     (acc_w),
      .fetch_vld  (fetch_vld),
      .fetch_addr (fetch_addr)
   );

   b4rp_banks #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_banks (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en_i),
      .wr_addr (wr_addr_i),
      .wr_data (wr_data_i),
      .rd_en   (fetch_vld),
      .rd_addr (fetch_addr),
      .rd_vld  (burst_vld),
      .rd_data (burst_data)
   );

   b4rp_serial #(.WORD_W(WORD_W)) u_serial (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (burst_vld),
      .in_data  (burst_data),
      .out_vld  (rd_vld_o),
      .out_rise (rd_rise_o),
      .out_fall (rd_fall_o)
   );
endmodule

// File: rtl/b4rp_chk.sv
module b4rp_chk #(
   parameter int WORD_W = 18
) (
   input logic              clk,
   input logic              rst,
   input logic              accept,
   input logic              out_vld,
   input logic [WORD_W-1:0] out_rise,
   input logic [WORD_W-1:0] out_fall
);
   assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_vld);

   assert_first_pair_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(accept, 3) && !$past(rst, 1) && !$past(rst, 2)) |-> out_vld);

   assert_second_pair_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(accept, 4) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> out_vld);

   assert_drop_next_R4: assert property (@(posedge clk) disable iff (rst)
      accept |=> !accept);

   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
      !out_vld |-> (out_rise == '0 && out_fall == '0));

   assert_valid_source_R6: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> ($past(accept, 3) || $past(accept, 4)));
endmodule

bind burst4_read_port b4rp_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .accept   (acc_w),
   .out_vld  (rd_vld_o),
   .out_rise (rd_rise_o),
   .out_fall (rd_fall_o)
);

// File: tb/burst4_read_port_tb.sv
module burst4_read_port_tb;
   localparam int W  = 18;
   localparam int D  = 256;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rd_sel_i = 1'b0;
   logic [AW-1:0] rd_addr_i = '0;
   logic          wr_en_i = 1'b0;
   logic [AW-1:0] wr_addr_i = '0;
   logic [4*W-1:0] wr_data_i = '0;
   logic          rd_vld_o;
   logic [W-1:0]  rd_rise_o, rd_fall_o;

   always #5 clk = ~clk;

   burst4_read_port u_dut (
      .clk(clk), .rst(rst), .rd_sel_i(rd_sel_i), .rd_addr_i(rd_addr_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_vld_o(rd_vld_o), .rd_rise_o(rd_rise_o), .rd_fall_o(rd_fall_o)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [4*W-1:0] mdl [D];
   logic           exp_v [16];
   logic [W-1:0]   exp_r [16];
   logic [W-1:0]   exp_f [16];
   string          exp_t [16];
   int  checks = 0;
   int  fails = 0;
   bit  last_acc = 1'b0;
   bit  finished = 1'b0;

   initial begin
      for (int i = 0; i < 16; i++) begin
         exp_v[i] = 1'b0; exp_r[i] = '0; exp_f[i] = '0; exp_t[i] = "R1";
      end
   end

   function automatic logic [4*W-1:0] pat(int a, int salt);
      logic [4*W-1:0] v;
      for (int k = 0; k < 4; k++) v[k*W +: W] = W'((a * 131 + k * 29 + salt * 977 + 7) ^ (k << 14));
      return v;
   endfunction

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic check_now();
      int i = cyc & 15;
      checks++;
      if (rd_vld_o !== exp_v[i] || rd_rise_o !== exp_r[i] || rd_fall_o !== exp_f[i]) begin
         fails++;
         $display("FAIL %s cyc=%0d actual vld=%0b rise=%h fall=%h expected vld=%0b rise=%h fall=%h",
                  exp_t[i], cyc, rd_vld_o, rd_rise_o, rd_fall_o, exp_v[i], exp_r[i], exp_f[i]);
      end
      exp_v[i] = 1'b0; exp_r[i] = '0; exp_f[i] = '0; exp_t[i] = "R6";
   endtask

   // one cycle: check the outputs, then drive inputs for the next rising edge
   task automatic step(bit r, bit rs, int ra, bit we, int wa, int salt, string tag);
      @(negedge clk);
      check_now();
      rst       = r;
      rd_sel_i  = rs;
      rd_addr_i = AW'(ra);
      wr_en_i   = we;
      wr_addr_i = AW'(wa);
      wr_data_i = we ? pat(wa, salt) : '0;
      if (r) begin
         last_acc = 1'b0;
      end else begin
         if (we) mdl[wa] = pat(wa, salt);        // same-edge write visible (R7)
         if (rs && !last_acc) begin
            int i1 = (cyc + 3) & 15;
            int i2 = (cyc + 4) & 15;
            logic [4*W-1:0] b = mdl[ra];
            exp_v[i1] = 1'b1; exp_r[i1] = b[0 +: W];   exp_f[i1] = b[W +: W];   exp_t[i1] = tag;
            exp_v[i2] = 1'b1; exp_r[i2] = b[2*W +: W]; exp_f[i2] = b[3*W +: W]; exp_t[i2] = tag;
            last_acc = 1'b1;
         end else begin
            last_acc = 1'b0;                         // dropped or idle (R4)
         end
      end
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 0, 1'b0, 0, 0, "R6");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog R2 actual=hung expected=complete");
         report();
      end
   end

   initial begin
      // R1: reset with read select held high
      repeat (4) step(1'b1, 1'b1, 5, 1'b0, 0, 0, "R1");
      // fill all bursts (R3 word placement)
      for (int a = 0; a < D; a++) step(1'b0, 1'b0, 0, 1'b1, a, 1, "R3");
      // R2 R3 R5: every address, reads every other edge, gapless output
      for (int a = 0; a < D; a++) begin
         step(1'b0, 1'b1, a, 1'b0, 0, 0, "R2_R3_R5");
         idle();
      end
      repeat (3) idle();
      // R4: select held high, every second request dropped
      for (int a = 0; a < 32; a++) step(1'b0, 1'b1, (a * 7 + 1) & (D - 1), 1'b0, 0, 0, "R4");
      repeat (4) idle();
      // R7 / R8: forwarding and late writes
      for (int t = 0; t < 16; t++) begin
         int x = (t * 17 + 3) & (D - 1);
         int y = (t * 23 + 9) & (D - 1);
         int z = (t * 41 + 5) & (D - 1);
         step(1'b0, 1'b1, x, 1'b1, x, 10 + t, "R7");
         idle();
         step(1'b0, 1'b0, 0, 1'b1, y, 30 + t, "R7");
         step(1'b0, 1'b1, y, 1'b0, 0, 0, "R7");
         idle();
         step(1'b0, 1'b1, z, 1'b0, 0, 0, "R8");
         step(1'b0, 1'b0, 0, 1'b1, z, 50 + t, "R8");
         idle();
         step(1'b0, 1'b1, z, 1'b0, 0, 0, "R8");
         repeat (3) idle();
      end
      // R6: isolated reads with growing gaps
      for (int g = 1; g <= 4; g++) begin
         step(1'b0, 1'b1, g * 13, 1'b0, 0, 0, "R6");
         repeat (g) idle();
      end
      repeat (8) idle();
      report();
   end
endmodule